// File: doc/BRIEF.md
# Bus Error Exception Classifier

This block sits next to a five-stage in-order RISC pipeline. It watches a bus-error strobe from the memory side and turns it into a single-cycle exception request. With that request it gives a flush mask, a cause code, a branch-delay flag and an exception program counter. Each error is first sorted by the kind of transaction that failed. Fetches, unscheduled loads and direct writes stay coupled to the pipeline, so they are synchronous. Scheduled loads and posted writes are decoupled from it, so they are asynchronous and may complete while any stage is busy.

A synchronous error gets a code from its transaction kind and is charged to the stage that owns it. An asynchronous error gets its code from the pipeline occupancy in that cycle. If an instruction sits in the late execute stage, the error takes the data code and is charged to that instruction. If not, it takes the instruction code and is charged to the oldest instruction in flight. The block then stays deaf to further strobes until the pipeline restarts at the exception vector.

Top module: `bus_err_classifier`

## Requirements
- R1: During and right after reset, `exc_req` is 0, `flush` is all zeros, and `cause`, `bd` and `epc` are all zeros.
- R2: An accepted strobe with `berr_kind` = 0 (fetch) yields cause 6 and is charged to stage 0. Stage indices are 0 = fetch, 1 = decode, 2 = first execute, 3 = late execute (X2), 4 = writeback.
- R3: An accepted strobe with `berr_kind` 1 (unscheduled load) or 3 (direct write) yields cause 7 and is charged to stage 3, whether or not stage 3 is valid. The unused values 5, 6 and 7 are handled the same way.
- R4: An accepted strobe with `berr_kind` 2 (scheduled load) or 4 (posted write) yields cause 7 and is charged to stage 3 when `stg_valid[3]` is 1 in that cycle.
- R5: An accepted strobe with `berr_kind` 2 or 4 while `stg_valid[3]` is 0 yields cause 6. It is charged to the highest-numbered valid stage, or to stage 0 when no stage is valid.
- R6: If the charged stage has its `stg_slot` bit set, `bd` becomes 1 and `epc` becomes that stage's PC minus 4. Otherwise `bd` becomes 0 and `epc` becomes that stage's PC.
- R7: A strobe is accepted when the block is idle. `exc_req` is then high for exactly the one cycle after the accepting edge. In that same cycle, `flush` has bit i set for every stage i from 0 up to the charged stage. In every other cycle `flush` is zero.
- R8: From the accepting edge until the edge at which `vec_restart` is high, strobes are ignored: no `exc_req`, and `cause`, `bd` and `epc` keep their values. A strobe in the same cycle as `vec_restart` is also ignored. A strobe in the following cycle is accepted.
- R9: Between exceptions, `cause`, `bd` and `epc` hold the values captured by the last accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_valid | input | 5 | Per-stage valid, bit i = stage i |
| stg_pc | input | 160 | Per-stage PC, stage i in bits [32i+31:32i] |
| stg_slot | input | 5 | Per-stage flag: instruction sits in a branch delay slot |
| berr_strobe | input | 1 | Bus error reported this cycle |
| berr_kind | input | 3 | Kind of failing transaction (0 fetch, 1 unscheduled load, 2 scheduled load, 3 direct write, 4 posted write) |
| vec_restart | input | 1 | Pipeline restarts at the exception vector this cycle |
| exc_req | output | 1 | One-cycle exception request |
| flush | output | 5 | Stages to flush, valid with exc_req |
| cause | output | 5 | Exception code: 6 instruction bus, 7 data bus |
| bd | output | 1 | Charged instruction is in a delay slot |
| epc | output | 32 | Exception program counter |

## Verification
Each of the five transaction kinds, plus one unused kind value, is sent with different patterns of stage occupancy. For asynchronous kinds, this shows whether the late-execute valid bit, rather than the kind, picks the code. It also shows whether the fallback charges the oldest valid stage or stage 0. Delay-slot flags are placed on the charged stage in some runs and on another stage in others, which separates a correct EPC adjustment from one keyed to the wrong stage. Strobes sent during the busy window, in the restart cycle and one cycle after it show exactly where acceptance reopens.

// File: rtl/bec_pkg.sv
package bec_pkg;
   typedef enum logic [2:0] {
      KIND_FETCH      = 3'd0,
      KIND_LD_UNSCHED = 3'd1,
      KIND_LD_SCHED   = 3'd2,
      KIND_WR_DIRECT  = 3'd3,
      KIND_WR_POSTED  = 3'd4
   } xact_kind_e;

   localparam int CAUSE_W = 5;
   localparam logic [CAUSE_W-1:0] CODE_IBUS = 5'd6;
   localparam logic [CAUSE_W-1:0] CODE_DBUS = 5'd7;
endpackage

// File: rtl/bec_kind_decode.sv
module bec_kind_decode
   import bec_pkg::*;
(
   input  logic [2:0] kind,
   output logic       is_async,
   output logic       is_fetch
);
   always_comb begin
      is_fetch = (kind == KIND_FETCH);
      is_async = (kind == KIND_LD_SCHED) || (kind == KIND_WR_POSTED);
   end
endmodule

// File: rtl/bec_attrib.sv
module bec_attrib #(
   parameter int N_STAGES = 5,
   parameter int X2_STAGE = 3,
   parameter int IDX_W    = 3
) (
   input  logic [N_STAGES-1:0] stg_valid,
   input  logic                is_async,
   input  logic                is_fetch,
   output logic [IDX_W-1:0]    attr_idx,
   output logic                use_dbus
);
   logic [IDX_W-1:0] oldest_idx;

   always_comb begin
      oldest_idx = '0;
      for (int i = 0; i < N_STAGES; i++) begin
         if (stg_valid[i]) oldest_idx = IDX_W'(i);
      end
   end

   always_comb begin
      if (!is_async) begin
         attr_idx = is_fetch ? '0 : IDX_W'(X2_STAGE);
         use_dbus = !is_fetch;
      end else if (stg_valid[X2_STAGE]) begin
         attr_idx = IDX_W'(X2_STAGE);
         use_dbus = 1'b1;
      end else begin
         attr_idx = oldest_idx;
         use_dbus = 1'b0;
      end
   end
endmodule

// File: rtl/bec_capture.sv
module bec_capture
   import bec_pkg::*;
#(
   parameter int N_STAGES   = 5,
   parameter int XLEN       = 32,
   parameter int IDX_W      = 3,
   parameter int INSN_BYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     berr_strobe,
   input  logic                     vec_restart,
   input  logic [IDX_W-1:0]         attr_idx,
   input  logic                     use_dbus,
   input  logic [N_STAGES*XLEN-1:0] stg_pc,
   input  logic [N_STAGES-1:0]      stg_slot,
   output logic                     exc_req,
   output logic [N_STAGES-1:0]      flush,
   output logic [CAUSE_W-1:0]       cause,
   output logic                     bd,
   output logic [XLEN-1:0]          epc,
   output logic                     busy
);
   logic                take;
   logic [XLEN-1:0]     sel_pc;
   logic                sel_slot;
   logic [N_STAGES-1:0] flush_d;

   assign take = berr_strobe && !busy;

   always_comb begin
      sel_pc   = '0;
      sel_slot = 1'b0;
      for (int i = 0; i < N_STAGES; i++) begin
         if (attr_idx == IDX_W'(i)) begin
            sel_pc   = stg_pc[i*XLEN +: XLEN];
            sel_slot = stg_slot[i];
         end
      end
   end

   for (genvar g = 0; g < N_STAGES; g++) begin : g_flush
      assign flush_d[g] = (IDX_W'(g) <= attr_idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exc_req <= 1'b0;
         flush   <= '0;
         cause   <= '0;
         bd      <= 1'b0;
         epc     <= '0;
         busy    <= 1'b0;
      end else begin
         exc_req <= take;
         flush   <= take ? flush_d : '0;
         if (take) begin
            busy  <= 1'b1;
            cause <= use_dbus ? CODE_DBUS : CODE_IBUS;
            bd    <= sel_slot;
            epc   <= sel_slot ? sel_pc - XLEN'(INSN_BYTES) : sel_pc;
         end else if (vec_restart) begin
            busy  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/bus_err_classifier.sv
module bus_err_classifier
   import bec_pkg::*;
#(
   parameter int N_STAGES   = 5,
   parameter int X2_STAGE   = 3,
   parameter int XLEN       = 32,
   parameter int INSN_BYTES = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_STAGES-1:0]      stg_valid,
   input  logic [N_STAGES*XLEN-1:0] stg_pc,
   input  logic [N_STAGES-1:0]      stg_slot,
   input  logic                     berr_strobe,
   input  logic [2:0]               berr_kind,
   input  logic                     vec_restart,
   output logic                     exc_req,
   output logic [N_STAGES-1:0]      flush,
   output logic [CAUSE_W-1:0]       cause,
   output logic                     bd,
   output logic [XLEN-1:0]          epc
);
   localparam int IDX_W = (N_STAGES > 1) ? $clog2(N_STAGES) : 1;

   if (X2_STAGE >= N_STAGES || X2_STAGE < 1) begin : g_bad_x2
      $error("X2_STAGE must lie inside the pipeline and after fetch");
   end
   if (INSN_BYTES < 1 || XLEN < 8) begin : g_bad_width
      $error("INSN_BYTES and XLEN out of range");
   end

   logic             is_async;
   logic             is_fetch;
   logic [IDX_W-1:0] attr_idx;
   logic             use_dbus;
   logic             busy;

   bec_kind_decode u_dec (
      .kind     (berr_kind),
      .is_async (is_async),
      .is_fetch (is_fetch)
   );

   bec_attrib #(.N_STAGES(N_STAGES), .X2_STAGE(X2_STAGE), .IDX_W(IDX_W)) u_attr (
      .stg_valid (stg_valid),
      .is_async  (is_async),
      .is_fetch  (is_fetch),
      .attr_idx  (attr_idx),
      .use_dbus  (use_dbus)
   );

   bec_capture #(.N_STAGES(N_STAGES), .XLEN(XLEN), .IDX_W(IDX_W),
                 .INSN_BYTES(INSN_BYTES)) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .berr_strobe (berr_strobe),
      .vec_restart (vec_restart),
      .attr_idx    (attr_idx),
      .use_dbus    (use_dbus),
      .stg_pc      (stg_pc),
      .stg_slot    (stg_slot),
      .exc_req     (exc_req),
      .flush       (flush),
      .cause       (cause),
      .bd          (bd),
      .epc         (epc),
      .busy        (busy)
   );
endmodule

// File: rtl/bus_err_classifier_chk.sv
module bus_err_classifier_chk #(
   parameter int N_STAGES = 5,
   parameter int X2_STAGE = 3,
   parameter int XLEN     = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic [N_STAGES-1:0] stg_valid,
   input logic                berr_strobe,
   input logic [2:0]          berr_kind,
   input logic                busy,
   input logic                exc_req,
   input logic [N_STAGES-1:0] flush,
   input logic [4:0]          cause,
   input logic                bd,
   input logic [XLEN-1:0]     epc
);
   logic [N_STAGES-1:0] flush_inc;
   assign flush_inc = flush + N_STAGES'(1);

   assert_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (berr_strobe && !busy) |=> exc_req);
   assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> !exc_req);
   assert_flush_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> (flush[0] && ((flush & flush_inc) == '0)));
   assert_flush_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_req |-> (flush == '0));
   assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !exc_req);
   assert_fetch_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (berr_strobe && !busy && berr_kind == 3'd0) |=> (cause == 5'd6));
   assert_async_x2_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (berr_strobe && !busy && (berr_kind == 3'd2 || berr_kind == 3'd4)
       && stg_valid[X2_STAGE]) |=> (cause == 5'd7));
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_req |-> ($stable(cause) && $stable(bd) && $stable(epc)));
endmodule

bind bus_err_classifier bus_err_classifier_chk #(
   .N_STAGES(N_STAGES), .X2_STAGE(X2_STAGE), .XLEN(XLEN)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .stg_valid   (stg_valid),
   .berr_strobe (berr_strobe),
   .berr_kind   (berr_kind),
   .busy        (busy),
   .exc_req     (exc_req),
   .flush       (flush),
   .cause       (cause),
   .bd          (bd),
   .epc         (epc)
);

// File: tb/bus_err_classifier_tb_top.sv
module bus_err_classifier_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  valid = '0;
   logic [4:0]  slot = '0;
   logic [31:0] pcs [5];
   logic [159:0] stg_pc;
   logic        strobe = 1'b0;
   logic [2:0]  kind = '0;
   logic        restart = 1'b0;
   logic        exc_req;
   logic [4:0]  flush;
   logic [4:0]  cause;
   logic        bd;
   logic [31:0] epc;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;
   string cur_tag = "R1";

   // reference model state
   bit          m_busy = 0;
   bit          m_req = 0;
   logic [4:0]  m_flush = '0;
   logic [4:0]  m_cause = '0;
   bit          m_bd = 0;
   logic [31:0] m_epc = '0;

   always #10 clk = ~clk;

   assign stg_pc = {pcs[4], pcs[3], pcs[2], pcs[1], pcs[0]};

   bus_err_classifier dut_i (
      .clk(clk), .rst_n(rst_n), .stg_valid(valid), .stg_pc(stg_pc),
      .stg_slot(slot), .berr_strobe(strobe), .berr_kind(kind),
      .vec_restart(restart), .exc_req(exc_req), .flush(flush),
      .cause(cause), .bd(bd), .epc(epc)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_req = 0; m_flush = '0; m_cause = '0; m_bd = 0; m_epc = '0;
      end else begin
         bit take;
         int tgt;
         take = strobe && !m_busy;
         m_req = take;
         m_flush = '0;
         if (take) begin
            if (kind == 3'd0) begin
               tgt = 0; m_cause = 5'd6;
            end else if (kind == 3'd2 || kind == 3'd4) begin
               if (valid[3]) begin
                  tgt = 3; m_cause = 5'd7;
               end else begin
                  tgt = 0;
                  for (int i = 0; i < 5; i++) if (valid[i]) tgt = i;
                  m_cause = 5'd6;
               end
            end else begin
               tgt = 3; m_cause = 5'd7;
            end
            for (int i = 0; i <= tgt; i++) m_flush[i] = 1'b1;
            m_bd  = slot[tgt];
            m_epc = slot[tgt] ? pcs[tgt] - 32'd4 : pcs[tgt];
            m_busy = 1;
         end else if (restart) begin
            m_busy = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         n_checks++;
         if (exc_req !== m_req || flush !== m_flush || cause !== m_cause ||
             bd !== m_bd || epc !== m_epc) begin
            n_fail++;
            $display("FAIL %s: got req=%0b flush=%b cause=%0d bd=%0b epc=%h, expected req=%0b flush=%b cause=%0d bd=%0b epc=%h",
                     cur_tag, exc_req, flush, cause, bd, epc,
                     m_req, m_flush, m_cause, m_bd, m_epc);
         end
      end
   end

   task automatic drive_at_edge();
      @(posedge clk);
      #2;
   endtask

   task automatic set_pcs(input logic [31:0] base);
      for (int i = 0; i < 5; i++) pcs[i] = base - 32'(i * 4);
   endtask

   task automatic one_err(input string tag, input logic [4:0] v, input logic [4:0] s,
                          input logic [2:0] k, input logic [31:0] base);
      drive_at_edge();
      cur_tag = tag;
      valid = v; slot = s; kind = k; set_pcs(base); strobe = 1'b1;
      drive_at_edge();
      strobe = 1'b0;
      repeat (3) drive_at_edge();
      cur_tag = "R9";
      restart = 1'b1;
      drive_at_edge();
      restart = 1'b0;
      drive_at_edge();
   endtask

   initial begin
      set_pcs(32'h0000_1000);
      cur_tag = "R1";
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      repeat (2) drive_at_edge();
      one_err("R2",  5'b11111, 5'b00000, 3'd0, 32'h0000_2000);
      one_err("R6",  5'b00011, 5'b00001, 3'd0, 32'h0000_2100);
      one_err("R3",  5'b11111, 5'b00001, 3'd1, 32'h0000_3000);
      one_err("R3",  5'b00001, 5'b01000, 3'd3, 32'h0000_3100);
      one_err("R3",  5'b11111, 5'b00000, 3'd6, 32'h0000_3200);
      one_err("R4",  5'b01000, 5'b01000, 3'd4, 32'h0000_4000);
      one_err("R4",  5'b11111, 5'b00100, 3'd2, 32'h0000_4100);
      one_err("R5",  5'b00111, 5'b00100, 3'd2, 32'h0000_5000);
      one_err("R5",  5'b10011, 5'b00010, 3'd4, 32'h0000_5100);
      one_err("R5",  5'b00000, 5'b00000, 3'd4, 32'h0000_5200);
      // R8: strobes while busy, in restart cycle, and one cycle after
      drive_at_edge();
      cur_tag = "R8";
      valid = 5'b11111; slot = 5'b00000; kind = 3'd1; set_pcs(32'h0000_6000);
      strobe = 1'b1;
      drive_at_edge();
      kind = 3'd0; set_pcs(32'h0000_6100);
      repeat (2) drive_at_edge();
      restart = 1'b1;
      drive_at_edge();
      restart = 1'b0; kind = 3'd4; valid = 5'b00011; slot = 5'b00010;
      set_pcs(32'h0000_6200);
      drive_at_edge();
      strobe = 1'b0;
      cur_tag = "R7";
      repeat (3) drive_at_edge();
      restart = 1'b1;
      drive_at_edge();
      restart = 1'b0;
      cur_tag = "R1";
      rst_n = 1'b0;
      repeat (2) drive_at_edge();
      rst_n = 1'b1;
      repeat (2) drive_at_edge();
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule